// File: doc/BRIEF.md
# Conversion Result Buffer

This block sits between an analog-to-digital converter and the host's read port. Each finished conversion result, a 12-bit two's-complement number, is pushed with a one-cycle write strobe. The push is accepted in that same cycle, so the converter can start its next conversion straight away. The host pulls results out in arrival order with a read strobe. Each result is presented as a 16-bit word, with the sign carried into the upper four bits.

Up to 512 results can wait in the buffer, which lets the host fall behind the sampling rate for a while. A 2-bit status output tells the host two things. One bit says whether any unread result is present. The other bit reports a sticky overflow error: it is raised when a result arrives while every slot is occupied, and that arriving result is discarded. A synchronous clear input empties the buffer and drops the error. Everything runs on one clock.

Top module: `sampleFifo`

## Requirements
- R1: After reset, rdData is 0 and statusOut is 2'b00.
- R2: Up to DEPTH (512) results can be pushed without a read and without raising the overflow bit. They are read back in the order they were pushed.
- R3: statusOut bit 0 (not-empty) is 1 exactly when at least one unread result is stored. It changes in the cycle after the accepted push or pop that changes it.
- R4: A read strobe while the buffer is non-empty places the oldest stored result on rdData in the cycle after the strobe, and removes that result.
- R5: rdData[11:0] equals the stored 12-bit value, and rdData[15:12] each equal its bit 11.
- R6: A push into a full buffer with no read in the same cycle is discarded. statusOut bit 1 (overflow) becomes 1 in the next cycle, and the discarded value is never returned.
- R7: Once set, the overflow bit stays 1 through reads and pushes until clear is asserted.
- R8: A read strobe while the buffer is empty leaves rdData and statusOut unchanged.
- R9: A simultaneous read and push on a full buffer is accepted without raising overflow. The buffer stays full, and the pushed value is returned after the older ones.
- R10: clear makes the buffer empty and statusOut 2'b00 in the next cycle. Read or push strobes in the same cycle are ignored.
- R11: A simultaneous read and push on an empty buffer stores the pushed value. The read is ignored, so rdData is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous flush of contents and error flag |
| wrStb | input | 1 | Push strobe from the converter side |
| wrData | input | 12 | Conversion result, two's complement |
| rdStb | input | 1 | Pop strobe from the host side |
| rdData | output | 16 | Sign-extended oldest result, registered |
| statusOut | output | 2 | Bit 0 not-empty, bit 1 sticky overflow |

## Verification
Every result of this block is due exactly one clock edge after the strobe that causes it. This holds for the registered read word, the not-empty bit and the overflow bit alike, because each is a single register fed from the strobes. The bench drives its strobes on the falling edge and compares the outputs on the next falling edge, so each comparison falls half a period after the only edge that could change them. For the unchanged-output cases, the bench compares the same outputs at that same point against the values captured before the stimulus.

// File: rtl/sample_fifo_pkg.sv
package sample_fifo_pkg;
  // Bit positions inside the status output, decoded by the host side.
  localparam int STAT_NOT_EMPTY = 0;
  localparam int STAT_OVERFLOW  = 1;
  localparam int STAT_W         = 2;

  // Strobes from control to datapath.
  typedef struct packed {
    logic push;   // store wrData at the write address
    logic pop;    // load the head entry into the output register
    logic flush;  // clear in progress
  } fifoStrobes_t;
endpackage

// File: rtl/sampleFifoCtrl.sv
module sampleFifoCtrl
  import sample_fifo_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         wrStb,
  input  logic         rdStb,
  output fifoStrobes_t strobes,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic [CW-1:0] fillCount,
  output logic         notEmpty,
  output logic         overflowErr
);
  localparam logic [CW-1:0] FULL_COUNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_ADDR  = AW'(DEPTH - 1);

  logic isEmpty;
  logic isFull;
  logic doPush;
  logic doPop;
  logic dropWrite;

  function automatic logic [AW-1:0] nextAddr(input logic [AW-1:0] a);
    return (a == LAST_ADDR) ? '0 : a + 1'b1;
  endfunction

  always_comb begin
    isEmpty   = (fillCount == '0);
    isFull    = (fillCount == FULL_COUNT);
    doPop     = rdStb && !isEmpty && !clear;
    doPush    = wrStb && !clear && (!isFull || doPop);
    dropWrite = wrStb && !clear && isFull && !doPop;
    strobes.push  = doPush;
    strobes.pop   = doPop;
    strobes.flush = clear;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrAddr      <= '0;
      rdAddr      <= '0;
      fillCount   <= '0;
      notEmpty    <= 1'b0;
      overflowErr <= 1'b0;
    end else if (clear) begin
      wrAddr      <= '0;
      rdAddr      <= '0;
      fillCount   <= '0;
      notEmpty    <= 1'b0;
      overflowErr <= 1'b0;
    end else begin
      if (doPush) wrAddr <= nextAddr(wrAddr);
      if (doPop)  rdAddr <= nextAddr(rdAddr);
      unique case ({doPush, doPop})
        2'b10: begin
          fillCount <= fillCount + 1'b1;
          notEmpty  <= 1'b1;
        end
        2'b01: begin
          fillCount <= fillCount - 1'b1;
          notEmpty  <= (fillCount != CW'(1));
        end
        default: ;
      endcase
      if (dropWrite) overflowErr <= 1'b1;
    end
  end
endmodule

// File: rtl/sampleFifoData.sv
module sampleFifoData
  import sample_fifo_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int IN_W  = 12,
  parameter int OUT_W = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobes_t     strobes,
  input  logic [AW-1:0]    wrAddr,
  input  logic [AW-1:0]    rdAddr,
  input  logic [IN_W-1:0]  wrData,
  output logic [OUT_W-1:0] rdData
);
  localparam int EXT_W = OUT_W - IN_W;

  logic [IN_W-1:0]  store [DEPTH];
  logic [IN_W-1:0]  headWord;
  logic [OUT_W-1:0] headExt;

  // Storage keeps the raw converter width; widening happens on the way out.
  always_ff @(posedge clk) begin
    if (strobes.push) store[wrAddr] <= wrData;
  end

  assign headWord = store[rdAddr];

  generate
    if (EXT_W > 0) begin : gSignExt
      assign headExt = {{EXT_W{headWord[IN_W-1]}}, headWord};
    end else begin : gNoExt
      assign headExt = headWord[OUT_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdData <= '0;
    else if (strobes.pop) rdData <= headExt;
  end
endmodule

// File: rtl/sampleFifo.sv
module sampleFifo
  import sample_fifo_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int IN_W  = 12,
  parameter int OUT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic              wrStb,
  input  logic [IN_W-1:0]   wrData,
  input  logic              rdStb,
  output logic [OUT_W-1:0]  rdData,
  output logic [STAT_W-1:0] statusOut
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  fifoStrobes_t  strobes;
  logic [AW-1:0] wrAddr;
  logic [AW-1:0] rdAddr;
  logic [CW-1:0] fillCount;
  logic          notEmpty;
  logic          overflowErr;

  sampleFifoCtrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) uCtrl (
    .clk(clk), .rstN(rstN), .clear(clear), .wrStb(wrStb), .rdStb(rdStb),
    .strobes(strobes), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .fillCount(fillCount), .notEmpty(notEmpty), .overflowErr(overflowErr)
  );

  sampleFifoData #(.DEPTH(DEPTH), .IN_W(IN_W), .OUT_W(OUT_W), .AW(AW)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrAddr(wrAddr),
    .rdAddr(rdAddr), .wrData(wrData), .rdData(rdData)
  );

  always_comb begin
    statusOut = '0;
    statusOut[STAT_NOT_EMPTY] = notEmpty;
    statusOut[STAT_OVERFLOW]  = overflowErr;
  end
endmodule

// File: rtl/sampleFifoChecker.sv
module sampleFifoChecker #(
  parameter int DEPTH = 512,
  parameter int IN_W  = 12,
  parameter int OUT_W = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             clear,
  input logic             wrStb,
  input logic             rdStb,
  input logic [OUT_W-1:0] rdData,
  input logic [1:0]       statusOut,
  input logic [CW-1:0]    fillCount
);
  localparam logic [CW-1:0] FULL_COUNT = CW'(DEPTH);

  // R5
  sign_ext_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdData[OUT_W-1:IN_W] == {(OUT_W-IN_W){rdData[IN_W-1]}});

  // R3
  not_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusOut[0] == (fillCount != '0));

  // R6
  drop_sets_error_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fillCount == FULL_COUNT && wrStb && !rdStb && !clear) |=> statusOut[1]);

  // R6
  drop_keeps_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fillCount == FULL_COUNT && wrStb && !rdStb && !clear) |=> fillCount == FULL_COUNT);

  // R7
  error_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut[1] && !clear) |=> statusOut[1]);

  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!statusOut[0] && rdStb && !wrStb && !clear) |=> ($stable(rdData) && $stable(statusOut)));

  // R9
  full_swap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fillCount == FULL_COUNT && wrStb && rdStb && !clear && !statusOut[1])
      |=> (!statusOut[1] && fillCount == FULL_COUNT));

  // R10
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (statusOut == 2'b00 && fillCount == '0));

  // R11
  empty_swap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!statusOut[0] && wrStb && rdStb && !clear) |=> ($stable(rdData) && statusOut[0]));
endmodule

bind sampleFifo sampleFifoChecker #(
  .DEPTH(DEPTH), .IN_W(IN_W), .OUT_W(OUT_W), .CW($clog2(DEPTH + 1))
) uChk (
  .clk(clk), .rstN(rstN), .clear(clear), .wrStb(wrStb), .rdStb(rdStb),
  .rdData(rdData), .statusOut(statusOut), .fillCount(fillCount)
);

// File: tb/tb_sampleFifo.sv
`timescale 1ns/1ps
module tb_sampleFifo;
  localparam int DEPTH = 512;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clear = 1'b0;
  logic        wrStb = 1'b0;
  logic [11:0] wrData = '0;
  logic        rdStb = 1'b0;
  logic [15:0] rdData;
  logic [1:0]  statusOut;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  sampleFifo dut (
    .clk(clk), .rstN(rstN), .clear(clear), .wrStb(wrStb), .wrData(wrData),
    .rdStb(rdStb), .rdData(rdData), .statusOut(statusOut)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Expected 16-bit word computed from the signed numeric value.
  function automatic logic [15:0] expWord(input int v);
    int s;
    s = (v >= 2048) ? v - 4096 : v;
    return 16'(s);
  endfunction

  function automatic logic [11:0] pattern(input int i);
    return 12'((i * 37 + 5) % 4096);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one cycle of strobes on a falling edge; return after the next falling edge.
  task automatic cyc(input bit w, input logic [11:0] d, input bit r, input bit c);
    wrStb = w; wrData = d; rdStb = r; clear = c;
    @(negedge clk);
    wrStb = 0; rdStb = 0; clear = 0;
  endtask

  initial begin
    logic [15:0] held;
    @(negedge clk);
    @(negedge clk);
    check("R1 rdData", 32'(rdData), 0);
    check("R1 status", 32'(statusOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 status after release", 32'(statusOut), 0);

    // R8: read while empty
    cyc(0, 12'h0, 1, 0);
    check("R8 rdData", 32'(rdData), 0);
    check("R8 status", 32'(statusOut), 0);

    // R5/R4/R3: every input code through the buffer
    for (int v = 0; v < 4096; v++) begin
      cyc(1, 12'(v), 0, 0);
      check("R3 not-empty after push", 32'(statusOut), 32'h1);
      cyc(0, 12'h0, 1, 0);
      check("R5 R4 sign-extended read", 32'(rdData), 32'(expWord(v)));
      check("R3 empty after pop", 32'(statusOut), 0);
    end

    // R2: fill to capacity
    for (int i = 0; i < DEPTH; i++) cyc(1, pattern(i), 0, 0);
    check("R2 full without overflow", 32'(statusOut), 32'h1);
    // R6: extra push dropped
    cyc(1, 12'h7FF, 0, 0);
    check("R6 overflow raised", 32'(statusOut), 32'h3);
    for (int i = 0; i < DEPTH; i++) begin
      cyc(0, 12'h0, 1, 0);
      check("R2 R6 order, dropped value absent", 32'(rdData), 32'(expWord(int'(pattern(i)))));
    end
    // R7: flag survives the reads
    check("R7 overflow sticky, empty", 32'(statusOut), 32'h2);
    cyc(1, 12'h123, 0, 0);
    check("R7 overflow sticky after push", 32'(statusOut), 32'h3);
    cyc(0, 12'h0, 1, 0);
    check("R7 read value", 32'(rdData), 32'h0123);
    held = rdData;
    // R8: empty read keeps last word and status
    cyc(0, 12'h0, 1, 0);
    check("R8 rdData held", 32'(rdData), 32'(held));
    check("R8 status held", 32'(statusOut), 32'h2);

    // R10: clear wins over simultaneous strobes
    cyc(1, 12'h456, 1, 1);
    check("R10 status cleared", 32'(statusOut), 0);
    cyc(0, 12'h0, 1, 0);
    check("R10 buffer empty", 32'(rdData), 32'(held));
    check("R10 still empty", 32'(statusOut), 0);

    // R9: read+push on full buffer
    for (int i = 0; i < DEPTH; i++) cyc(1, pattern(i + 100), 0, 0);
    cyc(1, 12'h800, 1, 0);
    check("R9 head out", 32'(rdData), 32'(expWord(int'(pattern(100)))));
    check("R9 no overflow", 32'(statusOut), 32'h1);
    cyc(1, 12'h801, 0, 0);
    check("R9 still full, push dropped", 32'(statusOut), 32'h3);
    for (int i = 1; i < DEPTH; i++) begin
      cyc(0, 12'h0, 1, 0);
      check("R9 order", 32'(rdData), 32'(expWord(int'(pattern(i + 100)))));
    end
    cyc(0, 12'h0, 1, 0);
    check("R9 swapped value last", 32'(rdData), 32'hF800);
    check("R9 empty", 32'(statusOut), 32'h2);
    cyc(0, 12'h0, 0, 1);
    check("R10 clear error", 32'(statusOut), 0);

    // R11: read+push on empty buffer
    held = rdData;
    cyc(1, 12'h0AB, 1, 0);
    check("R11 rdData unchanged", 32'(rdData), 32'(held));
    check("R11 stored", 32'(statusOut), 32'h1);
    cyc(0, 12'h0, 1, 0);
    check("R11 value read", 32'(rdData), 32'h00AB);

    // R10: clear with pending data
    for (int i = 0; i < 3; i++) cyc(1, 12'(12'hF00 + i), 0, 0);
    cyc(0, 12'h0, 0, 1);
    check("R10 clear pending", 32'(statusOut), 0);
    cyc(0, 12'h0, 1, 0);
    check("R10 pending gone", 32'(rdData), 32'h00AB);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule